// File: doc/BRIEF.md
# Carry-Skip Adder with OR-Propagate Bypass

This block is the combinational adder of a stack-machine arithmetic unit. It takes two operand words and a carry input. It returns their sum and the carry that leaves the top bit. Inside each bit group the sum bits come from a plain chain of full adders. Over each group sits a bypass predictor. When a carry enters a group whose every bit position would let a carry through, the predictor hands that carry straight to the next group. The carry does not wait to ripple bit by bit.

A bit position lets a carry through when either operand bit is one. The predictor therefore ANDs the group's incoming carry with the OR of each operand bit pair. Each group's outgoing carry is the OR of its rippled carry and its predicted carry. The groups are uneven. The lowest 2 bits form their own group, and the 30 bits above them form five 6-bit groups. Every group width and the group count are parameters. No register, clock or flag is part of the block.

Top module: `csk_adder`

## Requirements
- R1: For every input, `s` equals the low `WIDTH` bits of `x + y + cin`, where `WIDTH` is `LOW_W + GRP_W*NUM_GRP` (32 by default).
- R2: For every input, `cout` equals bit `WIDTH` of `x + y + cin`.
- R3: A group in which both operands are zero at every bit never passes a carry to the group above it. In particular, 0 + 0 + 1 gives `s` = 1 and `cout` = 0.
- R4: The lowest group covers bits 0 and 1. Its predicted carry is the three-input AND of `cin`, `x[0]|y[0]` and `x[1]|y[1]`. With `x` all ones, `y` = 0 and `cin` = 1, the result is `s` = 0 and `cout` = 1.
- R5: A group's predicted carry is raised only when its rippled carry-out is also 1. A group whose top bit has both operand bits set always carries out.
- R6: Adding two all-ones words with either carry-in gives `cout` = 1, and `s` equals all ones minus one plus `cin`.
- R7: Alternating bit patterns (0x5555_5555 and 0xAAAA_AAAA, in either order and with either carry-in) give the arithmetic sum.
- R8: The output is purely combinational. A new input gives its result within the same clock period, with no clock or reset involved.
- R9: The structure holds for any grouping. With `LOW_W`=2, `GRP_W`=2 and `NUM_GRP`=2, every one of the 2^13 input combinations gives the arithmetic sum and carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | First operand word |
| y | input | WIDTH | Second operand word |
| cin | input | 1 | Carry into bit 0 |
| s | output | WIDTH | Sum word |
| cout | output | 1 | Carry out of the top bit |

## Verification
A reduced 6-bit grouping is swept through every combination of operands and carry-in. This exposes any fault in how the low group, the upper groups and the combined group carries hand off to one another. On the full 32-bit word, all-ones plus one can only finish correctly through the bypass chain. All-ones plus all-ones separates generated carries from bypassed ones. Zero plus zero with carry-in shows that a killed group stops the carry. Alternating patterns give every group a mix of propagate and kill bits, so a predictor that ignores one bit of its group is caught. Random vectors then cover arbitrary mixes of these cases.

// File: rtl/csk_pkg.sv
package csk_pkg;
  // Default grouping: a narrow low group, then equal upper groups.
  localparam int DEF_LOW_W   = 2;
  localparam int DEF_GRP_W   = 6;
  localparam int DEF_NUM_GRP = 5;

  // Carry bundle handed from a group to the carry chain in the top.
  typedef struct packed {
    logic ripple;  // carry out of the last full adder in the group
    logic skip;    // predicted carry from the bypass logic
  } grp_carry_t;
endpackage

// File: rtl/csk_full_add.sv
module csk_full_add (
  input  logic a,
  input  logic b,
  input  logic cIn,
  output logic sum,
  output logic cOut
);
  logic halfSum;

  always_comb begin
    halfSum = a ^ b;
    sum     = halfSum ^ cIn;
    cOut    = (a & b) | (cIn & halfSum);
  end
endmodule

// File: rtl/csk_skip_pred.sv
module csk_skip_pred #(
  parameter int W = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cIn,
  output logic         skip
);
  logic [W-1:0] passBit;

  always_comb begin
    passBit = a | b;
    skip    = cIn & (&passBit);
  end
endmodule

// File: rtl/csk_group.sv
module csk_group
  import csk_pkg::*;
#(
  parameter int W = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cIn,
  output logic [W-1:0] sum,
  output grp_carry_t   cOut
);
  logic [W:0] rip;
  logic       skipC;

  assign rip[0] = cIn;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csk_full_add u_fa (
      .a   (a[i]),
      .b   (b[i]),
      .cIn (rip[i]),
      .sum (sum[i]),
      .cOut(rip[i+1])
    );
  end

  csk_skip_pred #(.W(W)) u_pred (
    .a   (a),
    .b   (b),
    .cIn (cIn),
    .skip(skipC)
  );

  always_comb begin
    cOut.ripple = rip[W];
    cOut.skip   = skipC;
  end

  always_comb begin
    if (!$isunknown({a, b, cIn})) begin
      // R5
      skip_sound_chk: assert (!cOut.skip || cOut.ripple)
        else $error("bypass predicted a carry the chain does not produce");
      // R5
      top_generate_chk: assert (!(a[W-1] && b[W-1]) || cOut.ripple)
        else $error("top bit generates but group carry is low");
      // R3
      group_kill_chk: assert ((|(a | b)) || !(cOut.ripple || cOut.skip))
        else $error("carry left a group with all operand bits zero");
    end
  end
endmodule

// File: rtl/csk_adder.sv
module csk_adder
  import csk_pkg::*;
#(
  parameter  int LOW_W   = DEF_LOW_W,
  parameter  int GRP_W   = DEF_GRP_W,
  parameter  int NUM_GRP = DEF_NUM_GRP,
  localparam int WIDTH   = LOW_W + GRP_W * NUM_GRP
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] s,
  output logic             cout
);
  localparam int NGRP_ALL = NUM_GRP + 1;

  logic [NGRP_ALL:0] chainC;
  grp_carry_t        grpC [NGRP_ALL];

  assign chainC[0] = cin;

  csk_group #(.W(LOW_W)) u_low (
    .a   (x[LOW_W-1:0]),
    .b   (y[LOW_W-1:0]),
    .cIn (chainC[0]),
    .sum (s[LOW_W-1:0]),
    .cOut(grpC[0])
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LSB = LOW_W + g * GRP_W;
    csk_group #(.W(GRP_W)) u_grp (
      .a   (x[LSB +: GRP_W]),
      .b   (y[LSB +: GRP_W]),
      .cIn (chainC[g+1]),
      .sum (s[LSB +: GRP_W]),
      .cOut(grpC[g+1])
    );
  end

  for (genvar k = 0; k < NGRP_ALL; k++) begin : g_chain
    assign chainC[k+1] = grpC[k].ripple | grpC[k].skip;
  end

  assign cout = chainC[NGRP_ALL];

  always_comb begin
    if (!$isunknown({x, y, cin})) begin
      // R1 R2
      sum_match_chk: assert ({cout, s} == ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin}))
        else $error("sum does not match arithmetic result");
      // R2
      msb_generate_chk: assert (!(x[WIDTH-1] && y[WIDTH-1]) || cout)
        else $error("top bits both set but no carry out");
    end
  end
endmodule

// File: tb/test_csk_adder.sv
module test_csk_adder;
  localparam int W  = 32;
  localparam int WS = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0]  x, y;
  logic          cin;
  logic [W-1:0]  s;
  logic          cout;

  logic [WS-1:0] xs, ys;
  logic          cs;
  logic [WS-1:0] ss;
  logic          couts;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  csk_adder i_csk_adder (
    .x(x), .y(y), .cin(cin), .s(s), .cout(cout)
  );

  csk_adder #(.LOW_W(2), .GRP_W(2), .NUM_GRP(2)) i_csk_small (
    .x(xs), .y(ys), .cin(cs), .s(ss), .cout(couts)
  );

  task automatic run32(input string tag, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic c);
    logic [W:0] expV;
    @(posedge clk);
    #1;
    x = a; y = b; cin = c;
    expV = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    @(negedge clk);
    nChecks++;
    if ({cout, s} !== expV) begin
      nFail++;
      $display("FAIL %s: x=%h y=%h cin=%0d got cout=%0d s=%h exp cout=%0d s=%h",
               tag, a, b, c, cout, s, expV[W], expV[W-1:0]);
    end
  endtask

  initial begin
    x = '0; y = '0; cin = 1'b0;
    xs = '0; ys = '0; cs = 1'b0;
    // R8: rest state with zero inputs, result visible within the period
    run32("R8", 32'h0, 32'h0, 1'b0);
    // R3: zero plus zero with carry-in stops at bit 0
    run32("R3", 32'h0, 32'h0, 1'b1);
    // R4: all ones plus carry-in rides the bypass through every group
    run32("R4", 32'hFFFF_FFFF, 32'h0, 1'b1);
    run32("R4", 32'hFFFF_FFFF, 32'h1, 1'b0);
    run32("R4", 32'h0, 32'hFFFF_FFFF, 1'b1);
    // R6: all ones plus all ones
    run32("R6", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run32("R6", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    // R7: alternating patterns
    run32("R7", 32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
    run32("R7", 32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    run32("R7", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    run32("R7", 32'h5555_5555, 32'h5555_5555, 1'b1);
    run32("R7", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);
    // R5: generate at each group's top bit, bypass across single groups
    for (int g = 0; g < 6; g++) begin
      int top;
      top = (g == 0) ? 1 : 1 + 6 * g;
      run32("R5", 32'h1 << top, 32'h1 << top, 1'b0);
      run32("R5", 32'hFFFF_FFFF >> (31 - top), 32'h0, 1'b1);
    end
    // R1 R2: random vectors
    for (int i = 0; i < 1500; i++) begin
      run32("R1/R2", $urandom, $urandom, 1'($urandom));
    end
    // R9: exhaustive sweep of the 6-bit grouping
    for (int v = 0; v < (1 << (2 * WS + 1)); v++) begin
      logic [WS:0] expS;
      logic [12:0] vec;
      vec = 13'(v);
      @(posedge clk);
      #1;
      {xs, ys, cs} = vec;
      expS = {1'b0, vec[12:7]} + {1'b0, vec[6:1]} + {6'b0, vec[0]};
      @(negedge clk);
      nChecks++;
      if ({couts, ss} !== expS) begin
        nFail++;
        $display("FAIL R9: x=%h y=%h cin=%0d got %h exp %h",
                 vec[12:7], vec[6:1], vec[0], {couts, ss}, expS);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule